// File: doc/BRIEF.md
# Audio Stream Control Sequencer

This block sequences one direction (transmit or receive) of an audio serial port. A register interface hands it configuration requests and trigger commands. The block then keeps one of five states: not-ready, ready, running, stopping or error. The data path reports block completion, an empty queue, and underrun or overrun events. From these the sequencer produces three things: a run enable for the serializer, a one-cycle flush strobe for the queue, and a one-cycle error response whenever a request is not legal in the current state.

The block offers three ways to halt a running stream:

- **Stop** ends at the next block boundary. Nothing is flushed, so a later start carries on from where the stream halted.
- **Drain** (transmit only) waits until the last queued block has gone out. On a receive port, drain acts exactly like stop.
- **Drop** halts at once and flushes the queue.

A fault parks the sequencer in the error state. Only a prepare command (or drop) brings it back to ready. The block also gates queue writes, accepting them only while ready or running.

Top module: `audio_stream_seq`

## Requirements
- R1: Reset leaves state 0 (not-ready). A configure request (`cfg_req`) with a non-zero rate, issued in not-ready or ready, moves the state to 1 (ready). A configure request in any other state raises `cmd_err` and leaves the state unchanged.
- R2: A configure request with `cfg_rate_zero`=1, issued in not-ready or ready, moves the state to 0 (not-ready).
- R3: Start (`cmd_op`=0) is legal only in ready and moves the state to 2 (running).
- R4: Stop (`cmd_op`=1) is legal only in running. It moves the state to 3 (stopping). The state then returns to ready on the first `blk_end`, with no flush.
- R5: Drain (`cmd_op`=2) is legal only in running and moves the state to stopping. With `dir_tx`=1, the state returns to ready on a `blk_end` seen while `q_empty`=1. With `dir_tx`=0, drain completes on any `blk_end`, as stop does.
- R6: Drop (`cmd_op`=3) is legal in every state except not-ready. It moves the state to ready and pulses `flush` for one cycle. In that cycle `run_en` is already low.
- R7: Prepare (`cmd_op`=4) is legal only in error (state 4) and moves the state to ready.
- R8: While running or stopping, `underrun` (when `dir_tx`=1) or `overrun` (when `dir_tx`=0) moves the state to 4 (error). The fault input of the other direction is ignored.
- R9: `wr_accept` follows `wr_req` only in ready or running, and is low in every other state.
- R10: Any illegal command, including an undefined `cmd_op` value (5 to 7), leaves the state unchanged. It raises `cmd_err` for exactly one cycle, in the cycle after the command.
- R11: `run_en` is high in running and stopping, and low in all other states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_tx | input | 1 | 1 = transmit direction, 0 = receive direction |
| cfg_req | input | 1 | Configure request strobe |
| cfg_rate_zero | input | 1 | Configure request carries a zero frame rate |
| cmd_valid | input | 1 | Trigger command strobe |
| cmd_op | input | 3 | Trigger code: 0 start, 1 stop, 2 drain, 3 drop, 4 prepare |
| blk_end | input | 1 | Data path finished the current block |
| q_empty | input | 1 | Transfer queue holds no further blocks |
| underrun | input | 1 | Transmit underrun event |
| overrun | input | 1 | Receive overrun event |
| wr_req | input | 1 | Queue write request |
| wr_accept | output | 1 | Queue write accepted |
| run_en | output | 1 | Serializer run enable |
| flush | output | 1 | One-cycle queue flush strobe |
| state | output | 3 | Current state: 0 not-ready, 1 ready, 2 running, 3 stopping, 4 error |
| cmd_err | output | 1 | One-cycle illegal-command response |

## Verification
The assertions assume that the register interface never raises `cfg_req` and `cmd_valid` in the same cycle. They also assume that an illegal request never coincides with `blk_end` while stopping. If either happens, the command is discarded or the block completion proceeds, so the state change no longer traces back to the command alone. The stimulus drives one strobe per cycle and presents `blk_end` only on idle cycles, which keeps it inside these limits. It raises fault inputs from running as well as from states where they must have no effect.

// File: rtl/audio_stream_seq.sv
module audio_stream_seq #(
  parameter int OP_W = 3,
  parameter int ST_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            dir_tx,
  input  logic            cfg_req,
  input  logic            cfg_rate_zero,
  input  logic            cmd_valid,
  input  logic [OP_W-1:0] cmd_op,
  input  logic            blk_end,
  input  logic            q_empty,
  input  logic            underrun,
  input  logic            overrun,
  input  logic            wr_req,
  output logic            wr_accept,
  output logic            run_en,
  output logic            flush,
  output logic [ST_W-1:0] state,
  output logic            cmd_err
);
  localparam logic [ST_W-1:0] S_NREADY = ST_W'(0);
  localparam logic [ST_W-1:0] S_READY  = ST_W'(1);
  localparam logic [ST_W-1:0] S_RUN    = ST_W'(2);
  localparam logic [ST_W-1:0] S_STOP   = ST_W'(3);
  localparam logic [ST_W-1:0] S_ERR    = ST_W'(4);

  localparam logic [OP_W-1:0] OP_START = OP_W'(0);
  localparam logic [OP_W-1:0] OP_HALT  = OP_W'(1);
  localparam logic [OP_W-1:0] OP_DRAIN = OP_W'(2);
  localparam logic [OP_W-1:0] OP_DROP  = OP_W'(3);
  localparam logic [OP_W-1:0] OP_PREP  = OP_W'(4);

  logic            wait_empty, wait_empty_nx;
  logic [ST_W-1:0] st_nx;
  logic            err_nx, flush_nx;
  logic            active, fault, done;

  assign active    = (state == S_RUN) || (state == S_STOP);
  assign run_en    = active;
  assign wr_accept = wr_req && ((state == S_READY) || (state == S_RUN));
  assign fault     = dir_tx ? underrun : overrun;
  assign done      = (state == S_STOP) && blk_end && (!wait_empty || q_empty);

  always_comb begin
    st_nx         = done ? S_READY : state;
    wait_empty_nx = wait_empty;
    err_nx        = 1'b0;
    flush_nx      = 1'b0;
    if (cfg_req) begin
      if (state == S_NREADY || state == S_READY)
        st_nx = cfg_rate_zero ? S_NREADY : S_READY;
      else
        err_nx = 1'b1;
      if (cmd_valid) err_nx = 1'b1;
    end else if (active && fault) begin
      st_nx = S_ERR;
    end else if (cmd_valid) begin
      case (cmd_op)
        OP_START:
          if (state == S_READY) st_nx = S_RUN;
          else err_nx = 1'b1;
        OP_HALT:
          if (state == S_RUN) begin
            st_nx = S_STOP;
            wait_empty_nx = 1'b0;
          end else err_nx = 1'b1;
        OP_DRAIN:
          if (state == S_RUN) begin
            st_nx = S_STOP;
            wait_empty_nx = dir_tx;
          end else err_nx = 1'b1;
        OP_DROP:
          if (state != S_NREADY) begin
            st_nx = S_READY;
            flush_nx = 1'b1;
          end else err_nx = 1'b1;
        OP_PREP:
          if (state == S_ERR) st_nx = S_READY;
          else err_nx = 1'b1;
        default: err_nx = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_NREADY;
      wait_empty <= 1'b0;
      cmd_err    <= 1'b0;
      flush      <= 1'b0;
    end else begin
      state      <= st_nx;
      wait_empty <= wait_empty_nx;
      cmd_err    <= err_nx;
      flush      <= flush_nx;
    end
  end
endmodule

module audio_stream_seq_chk #(
  parameter int OP_W = 3,
  parameter int ST_W = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_req,
  input logic            cmd_valid,
  input logic [OP_W-1:0] cmd_op,
  input logic            wr_accept,
  input logic            run_en,
  input logic            flush,
  input logic [ST_W-1:0] state,
  input logic            cmd_err
);
  AST_RUN_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_en) |-> $past(cmd_valid && cmd_op == OP_W'(0) && !cfg_req)); // R3
  AST_FLUSH_FROM_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> ($past(cmd_valid && cmd_op == OP_W'(3)) && state == ST_W'(1) && !run_en)); // R6
  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_err && $past(state) != ST_W'(3)) |-> state == $past(state)); // R10
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> (!cmd_err || $past(cmd_valid || cfg_req))); // R10
  AST_FAULT_FROM_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_W'(4) && $past(state) != ST_W'(4)) |-> $past(run_en)); // R8
  AST_NREADY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_W'(0)) |-> (!wr_accept && !run_en)); // R9
  AST_PREP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_W'(4) && state == ST_W'(1)) |-> $past(cmd_valid)); // R7
endmodule

bind audio_stream_seq audio_stream_seq_chk #(.OP_W(OP_W), .ST_W(ST_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cmd_valid(cmd_valid),
  .cmd_op(cmd_op), .wr_accept(wr_accept), .run_en(run_en), .flush(flush),
  .state(state), .cmd_err(cmd_err));

// File: tb/audio_stream_seq_tb.sv
`timescale 1ns/1ps
module audio_stream_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_tx = 1'b1, cfg_req = 1'b0, cfg_rate_zero = 1'b0, cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic blk_end = 1'b0, q_empty = 1'b0, underrun = 1'b0, overrun = 1'b0, wr_req = 1'b0;
  logic wr_accept, run_en, flush, cmd_err;
  logic [2:0] state;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] st;
    logic       err;
    logic       fl;
    string      tag;
  } exp_t;
  exp_t expq[$];

  always #2.5 clk = ~clk;

  audio_stream_seq u_dut (
    .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx), .cfg_req(cfg_req),
    .cfg_rate_zero(cfg_rate_zero), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .blk_end(blk_end), .q_empty(q_empty), .underrun(underrun), .overrun(overrun),
    .wr_req(wr_req), .wr_accept(wr_accept), .run_en(run_en), .flush(flush),
    .state(state), .cmd_err(cmd_err));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: drive one cycle of stimulus and push the expected result.
  task automatic step(input bit cr, input bit rz, input bit cv, input logic [2:0] op,
                      input bit be, input bit qe, input bit ur, input bit ov,
                      input bit wr, input bit exp_wr,
                      input logic [2:0] est, input bit eerr, input bit efl,
                      input string tag);
    exp_t e;
    @(negedge clk);
    cfg_req = cr; cfg_rate_zero = rz; cmd_valid = cv; cmd_op = op;
    blk_end = be; q_empty = qe; underrun = ur; overrun = ov; wr_req = wr;
    #0.5;
    check(wr_accept == exp_wr, {tag, " wr_accept"}, wr_accept, exp_wr);
    e.st = est; e.err = eerr; e.fl = efl; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic idle(input logic [2:0] est, input string tag);
    step(0,0,0,3'd0,0,0,0,0,0,0, est,0,0, tag);
  endtask

  task automatic cmd(input logic [2:0] op, input logic [2:0] est, input bit eerr,
                     input bit efl, input string tag);
    step(0,0,1,op,0,0,0,0,0,0, est,eerr,efl, tag);
  endtask

  // Monitor: compare registered outputs just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        logic exp_run;
        e = expq.pop_front();
        exp_run = (e.st == 3'd2) || (e.st == 3'd3);
        check(state == e.st, {e.tag, " state"}, state, e.st);
        check(cmd_err == e.err, {e.tag, " cmd_err"}, cmd_err, e.err);
        check(flush == e.fl, {e.tag, " flush"}, flush, e.fl);
        check(run_en == exp_run, {e.tag, " run_en R11"}, run_en, exp_run);
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check(state == 3'd0, "R1 reset state", state, 0);
    check(run_en == 1'b0 && flush == 1'b0 && cmd_err == 1'b0, "R11 reset outputs", run_en, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // Transmit direction
    cmd(3'd0, 3'd0, 1, 0, "R3 start in not-ready");
    cmd(3'd3, 3'd0, 1, 0, "R6 drop in not-ready");
    step(0,0,0,0,0,0,0,0,1,0, 3'd0,0,0, "R9 write in not-ready");
    step(1,1,0,0,0,0,0,0,0,0, 3'd0,0,0, "R2 zero-rate config in not-ready");
    step(1,0,0,0,0,0,0,0,0,0, 3'd1,0,0, "R1 config to ready");
    step(1,0,0,0,0,0,0,0,0,0, 3'd1,0,0, "R1 config in ready");
    cmd(3'd4, 3'd1, 1, 0, "R7 prepare in ready");
    cmd(3'd1, 3'd1, 1, 0, "R4 stop in ready");
    cmd(3'd7, 3'd1, 1, 0, "R10 undefined opcode");
    idle(3'd1, "R10 error lasts one cycle");
    step(0,0,0,0,0,0,0,0,1,1, 3'd1,0,0, "R9 write in ready");
    cmd(3'd0, 3'd2, 0, 0, "R3 start from ready");
    step(0,0,0,0,0,0,0,0,1,1, 3'd2,0,0, "R9 write in running");
    step(1,0,0,0,0,0,0,0,0,0, 3'd2,1,0, "R1 config in running");
    cmd(3'd0, 3'd2, 1, 0, "R3 start in running");
    cmd(3'd1, 3'd3, 0, 0, "R4 stop from running");
    step(0,0,0,0,0,0,0,0,1,0, 3'd3,0,0, "R9 write in stopping");
    idle(3'd3, "R4 wait for block end");
    step(0,0,0,0,1,0,0,0,0,0, 3'd1,0,0, "R4 block end completes stop");
    cmd(3'd0, 3'd2, 0, 0, "R3 restart");
    cmd(3'd2, 3'd3, 0, 0, "R5 drain from running");
    step(0,0,0,0,1,0,0,0,0,0, 3'd3,0,0, "R5 tx block end with queue busy");
    step(0,0,0,0,1,1,0,0,0,0, 3'd1,0,0, "R5 tx block end with queue empty");
    cmd(3'd0, 3'd2, 0, 0, "R3 start again");
    step(0,0,0,0,0,0,0,1,0,0, 3'd2,0,0, "R8 overrun ignored on tx");
    step(0,0,0,0,0,0,1,0,0,0, 3'd4,0,0, "R8 underrun to error");
    step(0,0,0,0,0,0,0,0,1,0, 3'd4,0,0, "R9 write in error");
    cmd(3'd0, 3'd4, 1, 0, "R3 start in error");
    step(1,0,0,0,0,0,0,0,0,0, 3'd4,1,0, "R1 config in error");
    cmd(3'd4, 3'd1, 0, 0, "R7 prepare from error");
    cmd(3'd0, 3'd2, 0, 0, "R3 start for drop");
    cmd(3'd3, 3'd1, 0, 1, "R6 drop from running");
    idle(3'd1, "R6 flush lasts one cycle");
    cmd(3'd3, 3'd1, 0, 1, "R6 drop in ready");
    cmd(3'd0, 3'd2, 0, 0, "R3 start");
    cmd(3'd1, 3'd3, 0, 0, "R4 stop");
    cmd(3'd3, 3'd1, 0, 1, "R6 drop from stopping");
    step(0,0,0,0,0,0,1,0,0,0, 3'd1,0,0, "R8 underrun ignored in ready");

    // Receive direction
    @(negedge clk);
    dir_tx = 1'b0;
    cmd(3'd0, 3'd2, 0, 0, "R3 rx start");
    cmd(3'd2, 3'd3, 0, 0, "R5 rx drain");
    step(0,0,0,0,1,0,0,0,0,0, 3'd1,0,0, "R5 rx drain ends at block end");
    cmd(3'd0, 3'd2, 0, 0, "R3 rx restart");
    step(0,0,0,0,0,0,1,0,0,0, 3'd2,0,0, "R8 underrun ignored on rx");
    step(0,0,0,0,0,0,0,1,0,0, 3'd4,0,0, "R8 rx overrun to error");
    cmd(3'd3, 3'd1, 0, 1, "R6 drop from error");
    step(1,1,0,0,0,0,0,0,0,0, 3'd0,0,0, "R2 zero-rate config from ready");
    idle(3'd0, "R2 stays not-ready");

    wait (expq.size() == 0);
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule